// File: doc/BRIEF.md
# Page Write Buffer and Commit Engine

This block sits between a serial-memory bus controller and a small non-volatile array. A burst opens with a start-page command that carries the word address. Data-byte strobes then fill an eight-slot page latch. Slot selection uses only the low three address bits, which advance after each byte and wrap inside the page. When a burst carries more than eight bytes, the newest bytes overwrite the oldest ones. A stop strobe closes the burst.

When the stop strobe arrives, the write-protect input is sampled. If write protect is asserted, the latch is thrown away and a completion pulse follows at once. If it is clear, the engine enters a self-timed busy window that lasts exactly `BUSY_CYCLES` clocks. During the first eight cycles of that window, it scans the slots in ascending offset order and emits one array write for each slot filled during the burst. The busy flag lets the bus controller withhold acknowledges. The completion pulse marks the end of the window.

States: `ST_IDLE` (no burst open), `ST_FILL` (collecting bytes), `ST_PROGRAM` (scanning slots into the array, busy), `ST_SETTLE` (remainder of the busy window). Transitions:
- IDLE→FILL on start.
- FILL→FILL on a new start, which reloads the address.
- FILL→IDLE on stop with no bytes, or on stop with write protect set.
- FILL→PROGRAM on stop with bytes and write protect clear.
- PROGRAM→SETTLE after the last slot.
- PROGRAM or SETTLE→IDLE when the timer expires.

Inside FILL, start has priority over stop, and stop has priority over a byte strobe.

Top module: `pwb_commit_engine`

## Requirements
- R1: A start command latches the page bits (address bits 6..3) and the slot pointer (bits 2..0). Each byte goes to the current slot, then the pointer advances modulo 8 while the page bits stay fixed. Each array write address is {page, slot}.
- R2: When a burst holds more than 8 bytes, byte n lands in the same slot as byte n-8 and replaces it, so only the last 8 bytes are committed.
- R3: A stop that closes a burst holding at least one byte, with write protect low, raises busy in the next cycle. Busy then stays high for exactly `BUSY_CYCLES` consecutive cycles.
- R4: Array writes occur only while busy, in ascending slot order. Slot k is written in the (k+1)-th busy cycle.
- R5: Slots not written during the current burst produce no array write. Addresses outside the page are never written.
- R6: If write protect is high when stop arrives, no array write occurs and busy stays low. Done pulses in the next cycle.
- R7: Done is a one-cycle pulse in the cycle right after busy falls.
- R8: While busy, start, byte and stop strobes have no effect. They neither alter the committed data nor extend the window.
- R9: A stop that closes a burst with no bytes produces no busy, no done and no array write.
- R10: After reset, busy, done and the array write enable are low.
- R11: Write protect is sampled only at the stop. Changing it during the busy window does not cancel the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-page command strobe |
| start_addr_i | input | ADDR_W | Word address carried by the start command |
| byte_stb_i | input | 1 | Data byte strobe |
| byte_data_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Stop/commit strobe |
| wp_i | input | 1 | Hardware write protect, active high |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_wdata_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Self-timed commit in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle. The completion pulse of one commit can coincide with the start command of the next burst, because the engine is already idle during the done cycle. The bench waits until it sees done high, drives a start in that very cycle, and then writes and commits a byte. The per-cycle reference model demands that this burst opens and that its byte reaches the array. A start dropped at the boundary would show up as a missing write and a missing busy window.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FILL    = 2'd1,
        ST_PROGRAM = 2'd2,
        ST_SETTLE  = 2'd3
    } pwb_state_e;

endpackage

// File: rtl/pwb_page_latch.sv
module pwb_page_latch #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned ADDR_W     = 7,
    parameter int unsigned PAGE_BYTES = 8,
    localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
    localparam int unsigned PAGE_W    = ADDR_W - OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [ADDR_W-1:0]     load_addr_i,
    input  logic                  put_i,
    input  logic [DATA_W-1:0]     put_data_i,
    input  logic [OFF_W-1:0]      rd_idx_i,
    output logic [PAGE_W-1:0]     page_o,
    output logic [PAGE_BYTES-1:0] mask_o,
    output logic [DATA_W-1:0]     rd_data_o
);

    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  ptr_q;
    logic [DATA_W-1:0] slot_data [PAGE_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            ptr_q  <= '0;
        end else if (load_i) begin
            page_q <= load_addr_i[ADDR_W-1:OFF_W];
            ptr_q  <= load_addr_i[OFF_W-1:0];
        end else if (put_i) begin
            ptr_q  <= ptr_q + 1'b1;
        end
    end

    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
        logic [DATA_W-1:0] byte_q;
        logic              vld_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
                vld_q  <= 1'b0;
            end else if (load_i) begin
                vld_q  <= 1'b0;
            end else if (put_i && (ptr_q == OFF_W'(s))) begin
                byte_q <= put_data_i;
                vld_q  <= 1'b1;
            end
        end

        assign slot_data[s] = byte_q;
        assign mask_o[s]    = vld_q;
    end

    assign page_o    = page_q;
    assign rd_data_o = slot_data[rd_idx_i];

    // R1: page bits never move inside a burst
    p_page_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(page_q));

    // R2: a byte always lands in the slot after the previous one (modulo page)
    p_ptr_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (put_i && !load_i) |=> (ptr_q == OFF_W'($past(ptr_q) + 1'b1)));

endmodule

// File: rtl/pwb_busy_timer.sv
module pwb_busy_timer #(
    parameter int unsigned LIMIT = 64,
    localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    assign last_o = run_i && (cnt_q == CNT_W'(LIMIT - 1));

    // R3: the window can never run past its length
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < CNT_W'(LIMIT)));

endmodule

// File: rtl/pwb_ctrl_fsm.sv
module pwb_ctrl_fsm
    import pwb_pkg::*;
#(
    parameter int unsigned PAGE_BYTES = 8,
    localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  byte_stb_i,
    input  logic                  stop_i,
    input  logic                  wp_i,
    input  logic [PAGE_BYTES-1:0] mask_i,
    input  logic                  tmr_last_i,
    output logic                  load_o,
    output logic                  put_o,
    output logic [OFF_W-1:0]      scan_o,
    output logic                  arr_we_o,
    output logic                  busy_o,
    output logic                  done_o
);

    localparam logic [OFF_W-1:0] SCAN_LAST = OFF_W'(PAGE_BYTES - 1);

    pwb_state_e       state_q, state_d;
    logic [OFF_W-1:0] scan_q;
    logic             done_q;
    logic             close_any;
    logic             close_wp;
    logic             close_empty;

    assign close_any   = (state_q == ST_FILL) && !start_i && stop_i;
    assign close_empty = close_any && (mask_i == '0);
    assign close_wp    = close_any && (mask_i != '0) && wp_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (start_i)          state_d = ST_FILL;
                else if (close_empty) state_d = ST_IDLE;
                else if (close_wp)    state_d = ST_IDLE;
                else if (close_any)   state_d = ST_PROGRAM;
            end
            ST_PROGRAM: begin
                if (tmr_last_i)               state_d = ST_IDLE;
                else if (scan_q == SCAN_LAST) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (tmr_last_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_q <= '0;
            done_q <= 1'b0;
        end else begin
            scan_q <= (state_q == ST_PROGRAM) ? scan_q + 1'b1 : '0;
            done_q <= close_wp ||
                      (((state_q == ST_PROGRAM) || (state_q == ST_SETTLE)) && tmr_last_i);
        end
    end

    // outputs
    always_comb begin
        load_o   = 1'b0;
        put_o    = 1'b0;
        busy_o   = 1'b0;
        arr_we_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_o = start_i;
            end
            ST_FILL: begin
                load_o = start_i;
                put_o  = byte_stb_i && !start_i && !stop_i;
            end
            ST_PROGRAM: begin
                busy_o   = 1'b1;
                arr_we_o = mask_i[scan_q];
            end
            ST_SETTLE: begin
                busy_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign scan_o = scan_q;
    assign done_o = done_q;

    // R4: array writes only inside the busy window
    p_we_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> busy_o);

    // R7: done follows the fall of busy
    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R7: done lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: protected stop never opens a window
    p_wp_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        close_wp |=> (!busy_o && done_o));

    // R9: an empty burst leaves no trace
    p_empty_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        close_empty |=> (!busy_o && !done_o));

    // R8: strobes cannot cut a window short
    p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tmr_last_i) |=> busy_o);

endmodule

// File: rtl/pwb_commit_engine.sv
module pwb_commit_engine #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned PAGE_BYTES  = 8,
    parameter int unsigned BUSY_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              byte_stb_i,
    input  logic [DATA_W-1:0] byte_data_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [DATA_W-1:0] arr_wdata_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int unsigned OFF_W  = $clog2(PAGE_BYTES);
    localparam int unsigned PAGE_W = ADDR_W - OFF_W;

    logic                  load;
    logic                  put;
    logic [OFF_W-1:0]      scan;
    logic [PAGE_W-1:0]     page;
    logic [PAGE_BYTES-1:0] mask;
    logic [DATA_W-1:0]     rd_data;
    logic                  tmr_last;

    pwb_page_latch #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) latch_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .load_addr_i (start_addr_i),
        .put_i       (put),
        .put_data_i  (byte_data_i),
        .rd_idx_i    (scan),
        .page_o      (page),
        .mask_o      (mask),
        .rd_data_o   (rd_data)
    );

    pwb_busy_timer #(
        .LIMIT (BUSY_CYCLES)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_o),
        .last_o (tmr_last)
    );

    pwb_ctrl_fsm #(
        .PAGE_BYTES (PAGE_BYTES)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .byte_stb_i (byte_stb_i),
        .stop_i     (stop_i),
        .wp_i       (wp_i),
        .mask_i     (mask),
        .tmr_last_i (tmr_last),
        .load_o     (load),
        .put_o      (put),
        .scan_o     (scan),
        .arr_we_o   (arr_we_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    assign arr_addr_o  = {page, scan};
    assign arr_wdata_o = rd_data;

    // R10: quiet outputs right after reset
    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !arr_we_o));

    // R11: the window is not aborted by write protect changing
    p_wp_late_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $rose(wp_i) && !tmr_last) |=> busy_o);

endmodule

// File: tb/pwb_commit_engine_tb_top.sv
module pwb_commit_engine_tb_top;

    localparam int BUSY = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [6:0] start_addr_i = '0;
    logic       byte_stb_i = 1'b0;
    logic [7:0] byte_data_i = '0;
    logic       stop_i = 1'b0;
    logic       wp_i = 1'b0;
    logic       arr_we_o;
    logic [6:0] arr_addr_o;
    logic [7:0] arr_wdata_o;
    logic       busy_o;
    logic       done_o;

    always #4 clk = ~clk;

    pwb_commit_engine #(
        .DATA_W(8), .ADDR_W(7), .PAGE_BYTES(8), .BUSY_CYCLES(BUSY)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .byte_stb_i(byte_stb_i), .byte_data_i(byte_data_i), .stop_i(stop_i),
        .wp_i(wp_i), .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o),
        .arr_wdata_o(arr_wdata_o), .busy_o(busy_o), .done_o(done_o)
    );

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    int busy_run = 0;
    int busy_len = -1;
    bit done_flag = 0;

    // behavioural reference model
    int m_open, m_page, m_ptr, m_left, m_done, s_page;
    int m_byte[8];
    int m_vld[8];
    int s_byte[8];
    int s_vld[8];
    int img[128];

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_open = 0; m_page = 0; m_ptr = 0; m_left = 0; m_done = 0;
            for (int i = 0; i < 8; i++) begin m_vld[i] = 0; s_vld[i] = 0; end
        end else begin
            m_done = 0;
            if (m_left > 0) begin
                m_left = m_left - 1;
                if (m_left == 0) m_done = 1;
            end else if (start_i) begin
                m_open = 1;
                m_page = int'(start_addr_i) / 8;
                m_ptr  = int'(start_addr_i) % 8;
                for (int i = 0; i < 8; i++) m_vld[i] = 0;
            end else if (stop_i && m_open == 1) begin
                int cnt;
                cnt = 0;
                m_open = 0;
                for (int i = 0; i < 8; i++) cnt += m_vld[i];
                if (cnt > 0) begin
                    if (wp_i) m_done = 1;
                    else begin
                        m_left = BUSY;
                        s_page = m_page;
                        for (int i = 0; i < 8; i++) begin
                            s_vld[i] = m_vld[i]; s_byte[i] = m_byte[i];
                        end
                    end
                end
            end else if (byte_stb_i && m_open == 1) begin
                m_byte[m_ptr] = int'(byte_data_i);
                m_vld[m_ptr]  = 1;
                m_ptr = (m_ptr + 1) % 8;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int k;
            int e_we;
            k = BUSY - m_left;
            e_we = (m_left > 0 && k < 8) ? s_vld[k] : 0;
            chk("R3 busy", int'(busy_o), int'(m_left > 0));
            chk("R7 done", int'(done_o), m_done);
            chk("R4 write enable", int'(arr_we_o), e_we);
            if (e_we == 1 && arr_we_o) begin
                chk("R1 write address", int'(arr_addr_o), s_page * 8 + k);
                chk("R4 write data", int'(arr_wdata_o), s_byte[k]);
            end
            if (arr_we_o) img[arr_addr_o] = int'(arr_wdata_o);
            if (busy_o) busy_run++;
            else if (busy_run > 0) begin busy_len = busy_run; busy_run = 0; end
        end
    end

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        start_i = 0; byte_stb_i = 0; stop_i = 0;
    endtask

    task automatic open_burst(input int addr);
        cyc(); idle_inputs(); start_i = 1; start_addr_i = 7'(addr);
    endtask

    task automatic put_byte(input int d);
        cyc(); idle_inputs(); byte_stb_i = 1; byte_data_i = 8'(d);
    endtask

    task automatic close_burst(input bit wp);
        cyc(); idle_inputs(); stop_i = 1; wp_i = wp;
        cyc(); idle_inputs(); wp_i = 0;
    endtask

    task automatic settle();
        repeat (BUSY + 4) cyc();
    endtask

    task automatic report();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done_flag) begin
            done_flag = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            report();
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) img[i] = -1;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 busy at reset", int'(busy_o), 0);
        chk("R10 done at reset", int'(done_o), 0);
        chk("R10 we at reset", int'(arr_we_o), 0);
        rst_n = 1;
        repeat (2) cyc();

        // R2: ten bytes from page 3 slot 6 -> last eight survive
        open_burst(8'h1E);
        for (int b = 0; b < 10; b++) put_byte(8'h10 + b);
        close_burst(0);
        settle();
        chk("R2 slot6", img[8'h1E], 8'h18);
        chk("R2 slot7", img[8'h1F], 8'h19);
        chk("R2 slot0", img[8'h18], 8'h12);
        chk("R2 slot5", img[8'h1D], 8'h17);
        chk("R3 busy length", busy_len, BUSY);

        // R1 / R5: three bytes from page 4 slot 6 wrap to slot 0
        open_burst(8'h26);
        put_byte(8'hA0); put_byte(8'hA1); put_byte(8'hA2);
        close_burst(0);
        settle();
        chk("R1 slot6", img[8'h26], 8'hA0);
        chk("R1 slot7", img[8'h27], 8'hA1);
        chk("R1 wrapped slot0", img[8'h20], 8'hA2);
        chk("R5 unwritten slot1", img[8'h21], -1);
        chk("R5 next page untouched", img[8'h28], -1);

        // R6: write protect at stop discards the burst
        open_burst(8'h40);
        put_byte(8'h5A); put_byte(8'h5B);
        close_burst(1);
        settle();
        chk("R6 protected slot0", img[8'h40], -1);
        chk("R6 protected slot1", img[8'h41], -1);

        // R9: empty burst
        open_burst(8'h50);
        close_burst(0);
        cyc();
        chk("R9 no busy", int'(busy_o), 0);
        settle();

        // R8 / R11: strobes and write protect during the window
        open_burst(8'h60);
        put_byte(8'h55);
        close_burst(0);
        repeat (3) cyc();
        stop_i = 1;
        cyc(); idle_inputs(); start_i = 1; start_addr_i = 7'h70;
        cyc(); idle_inputs(); byte_stb_i = 1; byte_data_i = 8'h99;
        cyc(); idle_inputs(); wp_i = 1; stop_i = 1;
        cyc(); idle_inputs();
        settle();
        wp_i = 0;
        chk("R11 commit survives late wp", img[8'h60], 8'h55);
        chk("R8 ignored write", img[8'h70], -1);
        chk("R8 window not extended", busy_len, BUSY);

        // done coinciding with the next start command
        open_burst(8'h10);
        put_byte(8'h33);
        close_burst(0);
        while (!done_o) cyc();
        idle_inputs(); start_i = 1; start_addr_i = 7'h08;
        put_byte(8'h77);
        close_burst(0);
        settle();
        chk("R7 start in done cycle accepted", img[8'h08], 8'h77);
        chk("R4 first burst kept", img[8'h10], 8'h33);

        done_flag = 1;
        report();
    end

endmodule